// File: doc/BRIEF.md
# Monitor Channel Activity Search

This block hunts for the first subscriber channel on a time-multiplexed serial frame whose remote end is asking for attention on the monitor channel. The frame carries a fixed number of channel slots. For each slot, the frame logic presents a valid strobe, the channel index and that channel's monitor handshake bit. A channel is active when its handshake bit is driven low.

The host starts a search by writing the command register with the search bit set. From the next slot strobe on, the block checks each slot in arrival order. On the first active slot it stores the channel index in an address register, sets an interrupt status bit and stops. Clearing the operational-mode enable abandons a search in progress and stops new ones from starting. The interrupt bit stays set until the host reads the status register. The stored address stays unchanged until another search succeeds.

Top module: `chan_hunt`

## Requirements
- R1: After reset, `busy` is 0, `irq_flag` is 0 and `hit_addr` is 0.
- R2: A command write (`cmd_wr`=1) with `cmd_search`=1 while `mode_en`=1 sets `busy` to 1 in the next cycle. A command write with `cmd_search`=0 leaves `busy` unchanged.
- R3: While `busy`=1, a slot with `slot_vld`=1 and `slot_hs`=0 sets `hit_addr` to that `slot_idx`, sets `irq_flag` to 1 and clears `busy`. All three changes appear in the next cycle. This holds for every index from 0 to the highest channel.
- R4: A slot with `slot_hs`=1, or a cycle with `slot_vld`=0, has no effect on a running search: `busy` stays 1 and `hit_addr` is unchanged.
- R5: Only the first active slot after arming is taken. Later active slots do not change `hit_addr`.
- R6: `mode_en`=0 clears `busy` in the next cycle, without setting `irq_flag` or changing `hit_addr`. A search command written while `mode_en`=0 does not arm the block.
- R7: `irq_flag` stays 1 until a status read (`stat_rd`=1) clears it in the next cycle. If a hit occurs in the same cycle as the read, the hit wins and `irq_flag` stays 1.
- R8: A search command written while `busy`=1 keeps `busy` at 1 and leaves `hit_addr` unchanged. A slot presented in that same cycle is not examined.
- R9: A slot presented in the same cycle as the arming command write is not examined. Scanning begins with the following strobe.
- R10: `hit_addr` holds its value through aborts, status reads and idle time, and changes only on the next successful search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe to the command register |
| cmd_search | input | 1 | Search bit of the written command |
| mode_en | input | 1 | Operational-mode enable level; 0 aborts a search |
| slot_vld | input | 1 | Slot strobe from the frame logic |
| slot_idx | input | CHAN_W (5) | Channel index of the current slot |
| slot_hs | input | 1 | Monitor handshake bit of the slot; 0 means active |
| stat_rd | input | 1 | Host read strobe of the status register |
| busy | output | 1 | 1 while a search is armed |
| irq_flag | output | 1 | Interrupt status: a channel was found |
| hit_addr | output | CHAN_W (5) | Index of the channel found by the last successful search |

## Verification
A wrong armed state shows up on `busy` one cycle after the command write or the abort. It also shows up one cycle after the first active slot, where `busy` must be low. A wrong qualification decision shows up in the same cycle as a wrong `hit_addr`, or as an `irq_flag` that should not have risen. The tests place active slots next to command writes, status reads and mode drops. This exposes a wrong priority between events one cycle after the conflict.

// File: rtl/chan_hunt_pkg.sv
package chan_hunt_pkg;

  typedef enum logic {
    HUNT_IDLE = 1'b0,
    HUNT_BUSY = 1'b1
  } hunt_st_e;

  // A slot qualifies when strobed and its handshake is driven low.
  function automatic logic slot_active(input logic vld, input logic hs);
    return vld & ~hs;
  endfunction

  // Next armed state. Order of precedence: mode drop, command, hit.
  function automatic hunt_st_e hunt_next(input hunt_st_e st,
                                         input logic mode_ok,
                                         input logic arm,
                                         input logic hit);
    hunt_st_e nx;
    nx = st;
    if (!mode_ok)  nx = HUNT_IDLE;
    else if (arm)  nx = HUNT_BUSY;
    else if (hit)  nx = HUNT_IDLE;
    return nx;
  endfunction

endpackage

// File: rtl/chan_hunt_qual.sv
module chan_hunt_qual
  import chan_hunt_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              scan_en,
  input  logic              slot_vld,
  input  logic [CHAN_W-1:0] slot_idx,
  input  logic              slot_hs,
  output logic              cand,
  output logic [CHAN_W-1:0] cand_idx
);

  always_comb begin
    cand     = scan_en & slot_active(slot_vld, slot_hs);
    cand_idx = slot_idx;
  end

endmodule

// File: rtl/chan_hunt_ctrl.sv
module chan_hunt_ctrl
  import chan_hunt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic arm_evt,
  input  logic hit_evt,
  output logic busy
);

  hunt_st_e st_q;
  hunt_st_e st_d;

  always_comb st_d = hunt_next(st_q, mode_en, arm_evt, hit_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= HUNT_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == HUNT_BUSY);

endmodule

// File: rtl/chan_hunt_latch.sv
module chan_hunt_latch #(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_evt,
  input  logic [CHAN_W-1:0] hit_idx,
  input  logic              stat_rd,
  output logic [CHAN_W-1:0] addr_q,
  output logic              irq_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (hit_evt) begin
        addr_q <= hit_idx;
        irq_q  <= 1'b1;
      end else if (stat_rd) begin
        irq_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/chan_hunt.sv
module chan_hunt #(
  parameter int NUM_CHAN = 32,
  parameter int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_search,
  input  logic              mode_en,
  input  logic              slot_vld,
  input  logic [CHAN_W-1:0] slot_idx,
  input  logic              slot_hs,
  input  logic              stat_rd,
  output logic              busy,
  output logic              irq_flag,
  output logic [CHAN_W-1:0] hit_addr
);

  // Named internal events, brought out for the checker.
  logic              arm_evt;
  logic              scan_en;
  logic              cand;
  logic [CHAN_W-1:0] cand_idx;
  logic              hit_evt;

  assign arm_evt = cmd_wr & cmd_search;
  // The cycle of a command write is never examined.
  assign scan_en = busy & mode_en & ~arm_evt;
  assign hit_evt = cand;

  chan_hunt_qual #(.CHAN_W(CHAN_W)) u_qual (
    .scan_en  (scan_en),
    .slot_vld (slot_vld),
    .slot_idx (slot_idx),
    .slot_hs  (slot_hs),
    .cand     (cand),
    .cand_idx (cand_idx)
  );

  chan_hunt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_en (mode_en),
    .arm_evt (arm_evt),
    .hit_evt (hit_evt),
    .busy    (busy)
  );

  chan_hunt_latch #(.CHAN_W(CHAN_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_evt (hit_evt),
    .hit_idx (cand_idx),
    .stat_rd (stat_rd),
    .addr_q  (hit_addr),
    .irq_q   (irq_flag)
  );

endmodule

// File: rtl/chan_hunt_chk.sv
module chan_hunt_chk #(
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en,
  input logic              stat_rd,
  input logic [CHAN_W-1:0] slot_idx,
  input logic              arm_evt,
  input logic              hit_evt,
  input logic              busy,
  input logic              irq_flag,
  input logic [CHAN_W-1:0] hit_addr
);

  // R2
  arm_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_evt && mode_en) |=> busy);

  // R3
  hit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (hit_addr == $past(slot_idx)) && irq_flag && !busy);

  // R6
  mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !busy);

  // R5
  busy_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(hit_evt) || !$past(mode_en)));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_evt |=> $stable(hit_addr));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !hit_evt) |=> !irq_flag);

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(hit_evt));

endmodule

bind chan_hunt chan_hunt_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_en  (mode_en),
  .stat_rd  (stat_rd),
  .slot_idx (slot_idx),
  .arm_evt  (arm_evt),
  .hit_evt  (hit_evt),
  .busy     (busy),
  .irq_flag (irq_flag),
  .hit_addr (hit_addr)
);

// File: tb/sim_chan_hunt.sv
`timescale 1ns/1ps
module sim_chan_hunt;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic          cmd_search = 1'b0;
  logic          mode_en = 1'b1;
  logic          slot_vld = 1'b0;
  logic [CW-1:0] slot_idx = '0;
  logic          slot_hs = 1'b1;
  logic          stat_rd = 1'b0;
  logic          busy;
  logic          irq_flag;
  logic [CW-1:0] hit_addr;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  chan_hunt u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_search(cmd_search),
    .mode_en(mode_en), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .slot_hs(slot_hs), .stat_rd(stat_rd), .busy(busy),
    .irq_flag(irq_flag), .hit_addr(hit_addr)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Inputs change at the falling edge; one call spans one rising edge.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cmd_wr = 0; cmd_search = 0; slot_vld = 0; slot_hs = 1; stat_rd = 0;
  endtask

  task automatic arm(input logic bitval);
    cmd_wr = 1; cmd_search = bitval;
    tick();
    idle_inputs();
  endtask

  task automatic slot(input int idx, input logic hs);
    slot_vld = 1; slot_idx = idx[CW-1:0]; slot_hs = hs;
    tick();
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R1", "busy", busy, 0);
    check("R1", "irq_flag", irq_flag, 0);
    check("R1", "hit_addr", hit_addr, 0);
  endtask

  task automatic t_basic_hunt();
    arm(1'b0);
    check("R2", "busy after write with bit 0", busy, 0);
    arm(1'b1);
    check("R2", "busy after arm", busy, 1);
    slot(3, 1'b1);
    check("R4", "busy after inactive slot", busy, 1);
    check("R4", "addr after inactive slot", hit_addr, 0);
    slot_vld = 0; slot_hs = 0; slot_idx = 5'd4; tick(); idle_inputs();
    check("R4", "busy after unstrobed low hs", busy, 1);
    slot(7, 1'b0);
    check("R3", "addr after hit", hit_addr, 7);
    check("R3", "irq after hit", irq_flag, 1);
    check("R3", "busy after hit", busy, 0);
    slot(9, 1'b0);
    check("R5", "addr after later active slot", hit_addr, 7);
    tick();
    check("R7", "irq held", irq_flag, 1);
    stat_rd = 1; tick(); idle_inputs();
    check("R7", "irq after read", irq_flag, 0);
    check("R10", "addr after read", hit_addr, 7);
  endtask

  task automatic t_abort();
    arm(1'b1);
    check("R2", "busy before abort", busy, 1);
    mode_en = 0; tick();
    check("R6", "busy after mode drop", busy, 0);
    check("R6", "irq after mode drop", irq_flag, 0);
    check("R10", "addr after abort", hit_addr, 7);
    arm(1'b1);
    check("R6", "arm with mode off", busy, 0);
    mode_en = 1; slot(15, 1'b0);
    check("R6", "no capture after abort", hit_addr, 7);
  endtask

  task automatic t_rearm();
    arm(1'b1);
    cmd_wr = 1; cmd_search = 1; slot_vld = 1; slot_idx = 5'd12; slot_hs = 0;
    tick(); idle_inputs();
    check("R8", "busy after rewrite", busy, 1);
    check("R8", "addr after rewrite", hit_addr, 7);
    check("R8", "irq after rewrite", irq_flag, 0);
    slot(20, 1'b0);
    check("R10", "addr on next hit", hit_addr, 20);
    stat_rd = 1; tick(); idle_inputs();
  endtask

  task automatic t_same_cycle_and_edges();
    cmd_wr = 1; cmd_search = 1; slot_vld = 1; slot_idx = 5'd5; slot_hs = 0;
    tick(); idle_inputs();
    check("R9", "busy after arm with slot", busy, 1);
    check("R9", "addr unchanged", hit_addr, 20);
    check("R9", "irq unchanged", irq_flag, 0);
    slot(31, 1'b0);
    check("R3", "top index captured", hit_addr, 31);
    arm(1'b1);
    check("R7", "irq still set while rearmed", irq_flag, 1);
    stat_rd = 1; slot_vld = 1; slot_idx = 5'd0; slot_hs = 0;
    tick(); idle_inputs();
    check("R7", "hit beats read", irq_flag, 1);
    check("R3", "index zero captured", hit_addr, 0);
    stat_rd = 1; tick(); idle_inputs();
    check("R7", "irq cleared", irq_flag, 0);
    repeat (3) tick();
    check("R10", "addr held idle", hit_addr, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_basic_hunt();
    t_abort();
    t_rearm();
    t_same_cycle_and_edges();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule